// File: doc/BRIEF.md
# OTP Fuse Programming Controller

This block is a register-mapped front end for a one-time-programmable fuse array. Software reaches it through a simple single-cycle register port. It selects a fuse word through an address field in the control register, and then starts one of two operations. A sense operation copies the addressed word into a read-data register. A program operation burns the contents of the program-data register into the addressed word. A program operation starts only when a 16-bit unlock key sits in the upper half of the control register.

Every operation runs three phases. The first is a relax interval, then an active strobe, then a second relax interval. All lengths come from a timing register and are counted in clock cycles. A busy flag in the control register covers the whole sequence. Writes that arrive while busy is high are dropped and raise a sticky error flag. The fuse array is a behavioural model in which programming can only set bits. Reset clears every register but leaves the array alone.

Top module: `fuse_prog_ctrl`

## Requirements
- R1: After reset, the control (offset 0x00), timing (0x10), program-data (0x30) and read-data (0x40) registers all read zero.
- R2: Control bits 6:0 select the fuse word as bank*8+word. Each of the 128 words is sensed and programmed independently of all the others.
- R3: Writing 1 to bit 0 of the read-control register (0x20) starts a sense. Control bit 8 (busy) reads 1 throughout the sense. Once busy drops, the read-data register holds the addressed word.
- R4: Writing the program-data register starts a program only when control bits 31:16 equal 0x3E77. With any other value, busy stays low and no fuse bit changes.
- R5: A program start clears control bits 31:16 to zero. A further program-data write without the key rewritten burns nothing.
- R6: Programming only sets bits. A sense returns the OR of every value programmed to that word.
- R7: Busy stays high for 2*(R+1)+S cycles, where R is timing bits 15:12. S is F-2*(R+1)+1 for F at least 2*(R+1), and 1 otherwise. F is timing bits 21:16 for a sense and bits 11:0 for a program.
- R8: Output fuse_strobe_o is high for exactly S cycles. It is preceded by R+1 busy cycles and followed by R+1 busy cycles, during which the strobe stays low.
- R9: While busy, writes to the control register, its set alias (0x04), its clear alias (0x08), read-control or program-data are ignored, and error bit 9 is set.
- R10: Error bit 9 is sticky. It clears only when 1 is written to bit 9 at the clear alias while idle. A direct control write does not clear it.
- R11: The set alias ORs the written value into the address and unlock fields. The clear alias removes the written 1 bits from those fields.
- R12: The read-data register changes only when a sense completes. Program operations leave it unchanged.
- R13: Reset clears the registers but keeps the fuse contents. A sense after reset returns the burned value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| fuse_strobe_o | output | 1 | Active fuse strobe |

## Verification
The hardest case to reach is a write that lands inside the busy window. The bench sets a long read strobe so that a sense lasts tens of cycles. It then issues control, read-control and program-data writes back to back while busy is still high. After busy drops, the bench checks that the address, program data and sensed result are untouched and that the error flag is set. Phase lengths are swept over relax values and strobe fields around the 2*(R+1) boundary, where the active strobe clamps to one cycle. The bench counts busy and strobe cycles on every clock.

// File: rtl/fuse_pkg.sv
`timescale 1ns/1ps
package fuse_pkg;
  localparam int DW       = 32;
  localparam int PG_W     = 12;
  localparam int RLX_W    = 4;
  localparam int RS_W     = 6;
  localparam int KEY_W    = 16;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'h3E77;

  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_SET   = 8'h04;
  localparam logic [7:0] OFF_CLR   = 8'h08;
  localparam logic [7:0] OFF_TIM   = 8'h10;
  localparam logic [7:0] OFF_RDC   = 8'h20;
  localparam logic [7:0] OFF_DATA  = 8'h30;
  localparam logic [7:0] OFF_RDATA = 8'h40;

  localparam int BIT_BUSY = 8;
  localparam int BIT_ERR  = 9;

  typedef enum logic [1:0] {PH_IDLE, PH_PRE, PH_STB, PH_POST} phase_e;
endpackage

// File: rtl/fuse_array.sv
`timescale 1ns/1ps
module fuse_array #(
  parameter int WORDS = 128,
  parameter int W     = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic [AW-1:0] addr_i,
  input  logic          burn_i,
  input  logic [W-1:0]  burn_data_i,
  output logic [W-1:0]  rd_data_o
);
  // behavioural fuse macro: blank at power-up, bits only ever set
  logic [W-1:0] mem [WORDS] = '{default: '0};

  always_ff @(posedge clk_i) begin
    if (burn_i) mem[addr_i] <= mem[addr_i] | burn_data_i;
  end

  assign rd_data_o = mem[addr_i];
endmodule

// File: rtl/fuse_seq.sv
`timescale 1ns/1ps
module fuse_seq
  import fuse_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_sense_i,
  input  logic             start_prog_i,
  input  logic [RLX_W-1:0] relax_i,
  input  logic [RS_W-1:0]  len_rd_i,
  input  logic [PG_W-1:0]  len_pg_i,
  output logic             busy_o,
  output logic             prog_o,
  output logic             strobe_o,
  output logic             done_o
);
  localparam int XW = PG_W + 1;

  phase_e            phase_q;
  logic [PG_W-1:0]   cnt_q, stb_q;
  logic [RLX_W-1:0]  rlx_q;
  logic              prog_q;
  logic [XW-1:0]     len_x, two_r;
  logic [PG_W-1:0]   stb_len;
  logic              start;

  assign start   = start_sense_i | start_prog_i;
  assign len_x   = start_prog_i ? {1'b0, len_pg_i} : XW'(len_rd_i);
  assign two_r   = XW'({relax_i, 1'b0}) + XW'(2);
  // active strobe = field minus both relax intervals, never below one cycle
  assign stb_len = (len_x >= two_r) ? PG_W'(len_x - two_r + XW'(1)) : PG_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      stb_q   <= '0;
      rlx_q   <= '0;
      prog_q  <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start) begin
          phase_q <= PH_PRE;
          cnt_q   <= PG_W'(relax_i);
          rlx_q   <= relax_i;
          stb_q   <= stb_len;
          prog_q  <= start_prog_i;
        end
        PH_PRE: if (cnt_q == '0) begin
          phase_q <= PH_STB;
          cnt_q   <= stb_q - PG_W'(1);
        end else cnt_q <= cnt_q - PG_W'(1);
        PH_STB: if (cnt_q == '0) begin
          phase_q <= PH_POST;
          cnt_q   <= PG_W'(rlx_q);
        end else cnt_q <= cnt_q - PG_W'(1);
        PH_POST: if (cnt_q == '0) phase_q <= PH_IDLE;
          else cnt_q <= cnt_q - PG_W'(1);
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o   = (phase_q != PH_IDLE);
  assign strobe_o = (phase_q == PH_STB);
  assign done_o   = strobe_o && (cnt_q == '0);
  assign prog_o   = prog_q;

  // checker: total busy length matches the timing formula
  logic [XW:0] ast_cnt_q, ast_exp_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ast_cnt_q <= '0;
      ast_exp_q <= '0;
    end else if (!busy_o && start) begin
      ast_cnt_q <= '0;
      ast_exp_q <= (XW+1)'(two_r) + (XW+1)'(stb_len);
    end else if (busy_o) begin
      ast_cnt_q <= ast_cnt_q + 1'b1;
    end
  end

  AST_BUSY_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ast_cnt_q == ast_exp_q); // R7
endmodule

// File: rtl/fuse_prog_ctrl.sv
`timescale 1ns/1ps
module fuse_prog_ctrl
  import fuse_pkg::*;
#(
  parameter int BANKS          = 16,
  parameter int WORDS_PER_BANK = 8,
  localparam int WORDS = BANKS * WORDS_PER_BANK,
  localparam int FAW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [7:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          fuse_strobe_o
);
  logic [FAW-1:0]   faddr_q;
  logic [KEY_W-1:0] unlock_q;
  logic             err_q;
  logic [PG_W-1:0]  t_pg_q;
  logic [RLX_W-1:0] t_rlx_q;
  logic [RS_W-1:0]  t_rs_q;
  logic [DW-1:0]    data_q, rdd_q, fuse_rd;

  logic seq_busy, seq_prog, seq_done;
  logic wr_ctrl, wr_set, wr_clr, wr_tim, wr_rdc, wr_data, guarded_wr;
  logic start_sense, start_prog, sense_cap, burn;

  assign wr_ctrl = wr_en_i && addr_i == OFF_CTRL;
  assign wr_set  = wr_en_i && addr_i == OFF_SET;
  assign wr_clr  = wr_en_i && addr_i == OFF_CLR;
  assign wr_tim  = wr_en_i && addr_i == OFF_TIM;
  assign wr_rdc  = wr_en_i && addr_i == OFF_RDC;
  assign wr_data = wr_en_i && addr_i == OFF_DATA;
  assign guarded_wr = wr_ctrl | wr_set | wr_clr | wr_rdc | wr_data;

  assign start_sense = wr_rdc && wdata_i[0] && !seq_busy;
  assign start_prog  = wr_data && unlock_q == UNLOCK_KEY && !seq_busy;
  assign sense_cap   = seq_done && !seq_prog;
  assign burn        = seq_done && seq_prog;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      faddr_q  <= '0;
      unlock_q <= '0;
      err_q    <= 1'b0;
      t_pg_q   <= '0;
      t_rlx_q  <= '0;
      t_rs_q   <= '0;
      data_q   <= '0;
      rdd_q    <= '0;
    end else begin
      if (guarded_wr && seq_busy) err_q <= 1'b1;
      if (!seq_busy) begin
        if (wr_ctrl) begin
          faddr_q  <= wdata_i[FAW-1:0];
          unlock_q <= wdata_i[DW-1 -: KEY_W];
        end
        if (wr_set) begin
          faddr_q  <= faddr_q | wdata_i[FAW-1:0];
          unlock_q <= unlock_q | wdata_i[DW-1 -: KEY_W];
        end
        if (wr_clr) begin
          faddr_q  <= faddr_q & ~wdata_i[FAW-1:0];
          unlock_q <= unlock_q & ~wdata_i[DW-1 -: KEY_W];
          if (wdata_i[BIT_ERR]) err_q <= 1'b0;
        end
        if (wr_tim) begin
          t_pg_q  <= wdata_i[PG_W-1:0];
          t_rlx_q <= wdata_i[PG_W +: RLX_W];
          t_rs_q  <= wdata_i[16 +: RS_W];
        end
        if (wr_data) begin
          data_q <= wdata_i;
          if (start_prog) unlock_q <= '0;  // one key per burn
        end
      end
      if (sense_cap) rdd_q <= fuse_rd;
    end
  end

  fuse_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_sense_i(start_sense),
    .start_prog_i (start_prog),
    .relax_i      (t_rlx_q),
    .len_rd_i     (t_rs_q),
    .len_pg_i     (t_pg_q),
    .busy_o       (seq_busy),
    .prog_o       (seq_prog),
    .strobe_o     (fuse_strobe_o),
    .done_o       (seq_done)
  );

  fuse_array #(.WORDS(WORDS), .W(DW)) u_array (
    .clk_i      (clk_i),
    .addr_i     (faddr_q),
    .burn_i     (burn),
    .burn_data_i(data_q),
    .rd_data_o  (fuse_rd)
  );

  logic [DW-1:0] ctrl_rd;
  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[FAW-1:0]        = faddr_q;
    ctrl_rd[BIT_BUSY]       = seq_busy;
    ctrl_rd[BIT_ERR]        = err_q;
    ctrl_rd[DW-1 -: KEY_W]  = unlock_q;
  end

  always_comb begin
    unique case (addr_i)
      OFF_CTRL, OFF_SET, OFF_CLR: rdata_o = ctrl_rd;
      OFF_TIM:   rdata_o = DW'({t_rs_q, t_rlx_q, t_pg_q});
      OFF_DATA:  rdata_o = data_q;
      OFF_RDATA: rdata_o = rdd_q;
      default:   rdata_o = '0;
    endcase
  end

  AST_PROG_NEEDS_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(seq_busy) && seq_prog) |-> $past(unlock_q) == UNLOCK_KEY); // R4
  AST_KEY_GONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_busy && seq_prog) |-> unlock_q == '0); // R5
  AST_BUSY_WRITE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_busy && guarded_wr) |=> err_q && $stable(faddr_q) && $stable(data_q)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_q) |-> $past(wr_clr && wdata_i[BIT_ERR])); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(seq_done && !seq_prog) |-> $stable(rdd_q)); // R12
endmodule

// File: tb/sim_fuse_prog_ctrl.sv
`timescale 1ns/1ps
module sim_fuse_prog_ctrl;
  localparam logic [7:0] A_CTRL = 8'h00, A_SET = 8'h04, A_CLR = 8'h08,
    A_TIM = 8'h10, A_RDC = 8'h20, A_DATA = 8'h30, A_RDATA = 8'h40;
  localparam logic [15:0] KEY = 16'h3E77;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, strobe;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] expv [128];

  always #2.5 clk = ~clk;

  fuse_prog_ctrl u0 (.clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .fuse_strobe_o(strobe));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    for (int i = 0; i < 10000; i++) begin
      rd(A_CTRL, c);
      if (!c[8]) break;
    end
  endtask

  task automatic sense(input int w, output logic [31:0] d);
    wr(A_CTRL, 32'(w)); wr(A_RDC, 32'h1); wait_idle(); rd(A_RDATA, d);
  endtask

  task automatic prog(input int w, input logic [31:0] v);
    wr(A_CTRL, {KEY, 16'(w)}); wr(A_DATA, v); wait_idle();
  endtask

  // samples from the negedge right after the start edge
  task automatic measure(output int nb, output int ns, output int npre);
    nb = 0; ns = 0; npre = 0;
    for (int i = 0; i < 500; i++) begin
      addr = A_CTRL; #1;
      if (!rdata[8]) break;
      nb++;
      if (strobe) ns++;
      else if (ns == 0) npre++;
      @(negedge clk);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d, v1, v2;
    int nb, ns, npre, s;
    for (int i = 0; i < 128; i++) expv[i] = '0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    // R1
    rd(A_CTRL, d);  chk("R1 ctrl", d, 0);
    rd(A_TIM, d);   chk("R1 timing", d, 0);
    rd(A_DATA, d);  chk("R1 data", d, 0);
    rd(A_RDATA, d); chk("R1 rdata", d, 0);

    wr(A_TIM, {10'd0, 6'd3, 4'd0, 12'd5});
    // R3 R2: blank array
    for (int w = 0; w < 128; w++) begin
      sense(w, d); chk("R3 blank sense", d, 0);
    end
    // R6 R2: two burns per word, OR expected
    for (int w = 0; w < 128; w++) begin
      v1 = (32'(w) * 32'h0101_0101) ^ 32'h0000_A5A5;
      v2 = (32'h1 << (w % 32)) | 32'h8000_0000;
      prog(w, v1);
      rd(A_CTRL, d); chk("R5 key cleared", d, 32'(w));
      prog(w, v2);
      expv[w] = v1 | v2;
    end
    for (int w = 0; w < 128; w++) begin
      sense(w, d); chk("R6 R2 OR sense", d, expv[w]);
    end

    // R4: wrong keys
    wr(A_CTRL, {16'h3E76, 16'd7}); wr(A_DATA, 32'hFFFF_FFFF);
    rd(A_CTRL, d); chk("R4 no busy", 32'(d[8]), 0);
    wr(A_CTRL, 32'd7); wr(A_DATA, 32'hFFFF_FFFF);
    rd(A_CTRL, d); chk("R4 no busy zero key", 32'(d[8]), 0);
    sense(7, d); chk("R4 unchanged", d, expv[7]);
    // R5: second data write without key
    wr(A_CTRL, {KEY, 16'd20}); wr(A_DATA, 32'h0); wait_idle();
    wr(A_DATA, 32'hFFFF_FFFF);
    rd(A_CTRL, d); chk("R5 no busy", 32'(d[8]), 0);
    sense(20, d); chk("R5 unchanged", d, expv[20]);

    // R7 R8 sweep
    for (int r = 0; r < 4; r++) begin
      int fl [4];
      fl[0] = 1; fl[1] = 2*r+1; fl[2] = 2*r+2; fl[3] = 2*r+7;
      for (int k = 0; k < 4; k++) begin
        s = (fl[k] >= 2*r+2) ? fl[k]-2*r-1 : 1;
        wr(A_TIM, {10'd0, 6'(fl[k]), 4'(r), 12'(fl[k]+3)});
        wr(A_CTRL, 32'd1); wr(A_RDC, 32'h1);
        measure(nb, ns, npre);
        chk("R7 sense busy", 32'(nb), 32'(2*r+2+s));
        chk("R8 strobe", 32'(ns), 32'(s));
        chk("R8 pre relax", 32'(npre), 32'(r+1));
        s = (fl[k]+3 >= 2*r+2) ? fl[k]+3-2*r-1 : 1;
        wr(A_CTRL, {KEY, 16'd1}); wr(A_DATA, 32'h0);
        measure(nb, ns, npre);
        chk("R7 prog busy", 32'(nb), 32'(2*r+2+s));
        chk("R8 prog strobe", 32'(ns), 32'(s));
      end
    end

    // R9: writes during a long sense
    wr(A_TIM, {10'd0, 6'd40, 4'd2, 12'd5});
    wr(A_DATA, 32'h1234_5678);
    wr(A_CTRL, 32'd3); wr(A_RDC, 32'h1);
    wr(A_CTRL, 32'd5); wr(A_SET, 32'h40); wr(A_RDC, 32'h1); wr(A_DATA, 32'hDEAD_BEEF);
    wait_idle();
    rd(A_CTRL, d);  chk("R9 ctrl kept, err set", d, 32'h0000_0203);
    rd(A_DATA, d);  chk("R9 data kept", d, 32'h1234_5678);
    rd(A_RDATA, d); chk("R9 sense result", d, expv[3]);
    // R10
    wr(A_CTRL, 32'd3); rd(A_CTRL, d); chk("R10 direct write keeps err", 32'(d[9]), 1);
    wr(A_CLR, 32'h0);  rd(A_CTRL, d); chk("R10 clr zero keeps err", 32'(d[9]), 1);
    wr(A_CLR, 32'h200); rd(A_CTRL, d); chk("R10 cleared", 32'(d[9]), 0);
    // R11
    wr(A_CTRL, 32'h10); wr(A_SET, 32'h05);
    rd(A_CTRL, d); chk("R11 set", d, 32'h15);
    wr(A_CLR, 32'h01); rd(A_CTRL, d); chk("R11 clr", d, 32'h14);
    wr(A_SET, 32'h3E77_0000); rd(A_CTRL, d); chk("R11 set key", d, 32'h3E77_0014);
    wr(A_CLR, 32'hFFFF_0000); rd(A_CTRL, d); chk("R11 clr key", d, 32'h14);

    // R12
    wr(A_TIM, {10'd0, 6'd3, 4'd0, 12'd5});
    sense(2, d);
    prog(9, 32'h0F00_0000); expv[9] |= 32'h0F00_0000;
    rd(A_RDATA, d); chk("R12 rdata held", d, expv[2]);

    // R13
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    rd(A_CTRL, d);  chk("R13 ctrl", d, 0);
    rd(A_TIM, d);   chk("R13 timing", d, 0);
    rd(A_DATA, d);  chk("R13 data", d, 0);
    rd(A_RDATA, d); chk("R13 rdata", d, 0);
    wr(A_TIM, {10'd0, 6'd3, 4'd0, 12'd5});
    sense(9, d); chk("R13 fuses kept", d, expv[9]);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule